// File: doc/BRIEF.md
# Split-Field Operand ALU with Link

This block is the 12-bit arithmetic unit of a small word-oriented processor, together with the accumulator and link flip-flop that take its results. Its A operand is formed by strobes from the sequencer. It can be the memory-address register, all ones, or two fields taken separately: the low field (bits 6:0) and the high field (bits 11:7), each from the memory data word or the program counter. A field with no source selected reads as zero. Memory bits 6:0 with no high source give page-zero addressing. Memory bits 6:0 with program-counter bits 11:7 give current-page addressing.

The B operand is the accumulator, all ones, or the constant one. One operation strobe selects the function: sum, bitwise AND, or the exclusive-OR of the operands plus one. The unit outputs the 12-bit result and a carry-out, which drives an increment-and-skip decision. It also outputs a proposed link value, equal to the stored link flipped by the carry. Write strobes capture the result into the accumulator, clear the accumulator, or store the proposed link. A zero flag taken from the stored accumulator feeds the skip logic.

Top module: `opsel_alu`

## Requirements
- R1: Operand A is the bitwise OR of every selected source. a_sel_ma gives ma_i. a_sel_ones gives octal 7777. a_lo_mem and a_lo_pc give bits 6:0 of mem_i and pc_i, and a_hi_mem and a_hi_pc give bits 11:7 of the same words. A field with no source selected is zero.
- R2: Operand B is the bitwise OR of the selected sources: b_sel_ac gives the stored accumulator, b_sel_ones gives 7777 and b_sel_one gives 0001. With none selected, B is zero.
- R3: With op_add, result is (A + B) mod 4096 and carry_out is bit 12 of the sum.
- R4: With op_and, result is A & B and carry_out is 0.
- R5: With op_incxor, result is ((A ^ B) + 1) mod 4096 and carry_out is 1 exactly when A ^ B equals 7777.
- R6: With no operation strobe, result and carry_out are 0. Asserting more than one operation strobe at once is illegal.
- R7: new_link always equals link_q XOR carry_out.
- R8: On a clock edge with ac_clr high, ac_q becomes 0 even if ac_wr is also high. With only ac_wr high, ac_q takes result. With neither high, ac_q holds.
- R9: On a clock edge with link_wr high, link_q takes new_link. Otherwise link_q holds.
- R10: ac_zero is high exactly when ac_q is zero.
- R11: While rst_n is low, ac_q and link_q are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ma_i | input | 12 | Memory-address register value |
| pc_i | input | 12 | Program counter value |
| mem_i | input | 12 | Memory data word |
| a_sel_ma | input | 1 | A takes ma_i |
| a_sel_ones | input | 1 | A takes 7777 |
| a_lo_mem | input | 1 | A bits 6:0 from mem_i |
| a_lo_pc | input | 1 | A bits 6:0 from pc_i |
| a_hi_mem | input | 1 | A bits 11:7 from mem_i |
| a_hi_pc | input | 1 | A bits 11:7 from pc_i |
| b_sel_ac | input | 1 | B takes the accumulator |
| b_sel_ones | input | 1 | B takes 7777 |
| b_sel_one | input | 1 | B takes 0001 |
| op_add | input | 1 | Operation A + B |
| op_and | input | 1 | Operation A & B |
| op_incxor | input | 1 | Operation (A ^ B) + 1 |
| ac_wr | input | 1 | Load accumulator from result |
| ac_clr | input | 1 | Clear accumulator (wins over ac_wr) |
| link_wr | input | 1 | Load link from new_link |
| result | output | 12 | ALU result |
| carry_out | output | 1 | Carry-out of the selected operation |
| new_link | output | 1 | Stored link XOR carry-out |
| ac_q | output | 12 | Stored accumulator |
| link_q | output | 1 | Stored link |
| ac_zero | output | 1 | Stored accumulator is zero |

## Verification
A wrong field boundary or a missing OR term in the operand muxes shows up on result in the same cycle, but only for source words whose bits differ across the field edge. For that reason the sweeps use words with mixed low and high fields. A wrong carry shows at once on both carry_out and new_link. A wrong accumulator or link update is invisible until the next cycle, when ac_q, ac_zero or link_q show it, or when a later operation that reads the accumulator as B gives a wrong result. Each register test therefore reads the stored value one edge after the write strobe.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;
  typedef enum logic [1:0] {
    ALU_NONE   = 2'd0,
    ALU_ADD    = 2'd1,
    ALU_AND    = 2'd2,
    ALU_INCXOR = 2'd3
  } alu_op_e;

  function automatic alu_op_e pick_op(input logic add, input logic andd,
                                      input logic incx);
    if (add)       return ALU_ADD;
    else if (andd) return ALU_AND;
    else if (incx) return ALU_INCXOR;
    else           return ALU_NONE;
  endfunction
endpackage

// File: rtl/opsel_alu_asel.sv
module opsel_alu_asel #(
  parameter int W    = 12,
  parameter int LO_W = 7
) (
  input  logic [W-1:0] ma_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] mem_i,
  input  logic         sel_ma,
  input  logic         sel_ones,
  input  logic         lo_mem,
  input  logic         lo_pc,
  input  logic         hi_mem,
  input  logic         hi_pc,
  output logic [W-1:0] a_o
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic whole;
    assign whole = (sel_ma & ma_i[gi]) | sel_ones;
    if (gi < LO_W) begin : g_lo
      assign a_o[gi] = whole | (lo_mem & mem_i[gi]) | (lo_pc & pc_i[gi]);
    end else begin : g_hi
      assign a_o[gi] = whole | (hi_mem & mem_i[gi]) | (hi_pc & pc_i[gi]);
    end
  end
endmodule

// File: rtl/opsel_alu_bsel.sv
module opsel_alu_bsel #(
  parameter int W = 12
) (
  input  logic [W-1:0] ac_i,
  input  logic         sel_ac,
  input  logic         sel_ones,
  input  logic         sel_one,
  output logic [W-1:0] b_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    b_o = '0;
    if (sel_ac)   b_o = b_o | ac_i;
    if (sel_ones) b_o = b_o | '1;
    if (sel_one)  b_o = b_o | ONE;
  end
endmodule

// File: rtl/opsel_alu_core.sv
module opsel_alu_core
  import opsel_alu_pkg::*;
#(
  parameter int W = 12
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] q_o,
  output logic         cout_o
);
  logic [W:0] wide;

  always_comb begin
    wide = '0;
    unique case (op)
      ALU_ADD:    wide = {1'b0, a_i} + {1'b0, b_i};
      ALU_AND:    wide = {1'b0, a_i & b_i};
      ALU_INCXOR: wide = {1'b0, a_i ^ b_i} + (W+1)'(1);
      default:    wide = '0;
    endcase
    q_o    = wide[W-1:0];
    cout_o = wide[W];
  end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu
  import opsel_alu_pkg::*;
#(
  parameter int W    = 12,
  parameter int LO_W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ma_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] mem_i,
  input  logic         a_sel_ma,
  input  logic         a_sel_ones,
  input  logic         a_lo_mem,
  input  logic         a_lo_pc,
  input  logic         a_hi_mem,
  input  logic         a_hi_pc,
  input  logic         b_sel_ac,
  input  logic         b_sel_ones,
  input  logic         b_sel_one,
  input  logic         op_add,
  input  logic         op_and,
  input  logic         op_incxor,
  input  logic         ac_wr,
  input  logic         ac_clr,
  input  logic         link_wr,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         new_link,
  output logic [W-1:0] ac_q,
  output logic         link_q,
  output logic         ac_zero
);
  logic [W-1:0] a_op, b_op, ac_d;
  logic         link_d, ac_en;
  alu_op_e      op;

  assign op = pick_op(op_add, op_and, op_incxor);

  opsel_alu_asel #(.W(W), .LO_W(LO_W)) u_asel (
    .ma_i(ma_i), .pc_i(pc_i), .mem_i(mem_i),
    .sel_ma(a_sel_ma), .sel_ones(a_sel_ones),
    .lo_mem(a_lo_mem), .lo_pc(a_lo_pc),
    .hi_mem(a_hi_mem), .hi_pc(a_hi_pc),
    .a_o(a_op)
  );

  opsel_alu_bsel #(.W(W)) u_bsel (
    .ac_i(ac_q), .sel_ac(b_sel_ac), .sel_ones(b_sel_ones),
    .sel_one(b_sel_one), .b_o(b_op)
  );

  opsel_alu_core #(.W(W)) u_core (
    .op(op), .a_i(a_op), .b_i(b_op), .q_o(result), .cout_o(carry_out)
  );

  assign new_link = link_q ^ carry_out;

  // next-state
  always_comb begin
    ac_en  = ac_wr | ac_clr;
    ac_d   = ac_clr ? '0 : result;
    link_d = new_link;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q <= '0;
    end else if (ac_en) begin
      ac_q <= ac_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
    end else if (link_wr) begin
      link_q <= link_d;
    end
  end

  assign ac_zero = (ac_q == '0);

  AST_OP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_add, op_and, op_incxor})); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_add | op_and | op_incxor) |-> (result == '0 && !carry_out)); // R6
  AST_AND_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    op_and |-> !carry_out); // R4
  AST_AC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ac_clr |=> ac_q == '0); // R8
  AST_AC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_wr && !ac_clr) |=> ac_q == $past(result)); // R8
  AST_AC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ac_wr && !ac_clr) |=> $stable(ac_q)); // R8
  AST_LINK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    link_wr |=> link_q == $past(link_q ^ carry_out)); // R9
  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !link_wr |=> $stable(link_q)); // R9
endmodule

// File: tb/opsel_alu_bench.sv
module opsel_alu_bench;
  localparam int W = 12;
  localparam logic [W-1:0] LOMASK = 12'o0177;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] ma_i, pc_i, mem_i;
  logic a_sel_ma, a_sel_ones, a_lo_mem, a_lo_pc, a_hi_mem, a_hi_pc;
  logic b_sel_ac, b_sel_ones, b_sel_one;
  logic op_add, op_and, op_incxor, ac_wr, ac_clr, link_wr;
  logic [W-1:0] result, ac_q;
  logic carry_out, new_link, link_q, ac_zero;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic model_link;

  always #5 clk = ~clk;

  opsel_alu u_opsel_alu (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [W-1:0] sample_val(input int i);
    case (i)
      0: return 12'o0000;
      1: return 12'o0001;
      2: return 12'o7777;
      3: return 12'o7776;
      4: return 12'o0177;
      5: return 12'o0200;
      default: return W'((i * i * 37 + i * 291 + 5) % 4096);
    endcase
  endfunction

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%o expected=%o", req, act, exp);
    end
  endtask

  task automatic idle();
    {a_sel_ma, a_sel_ones, a_lo_mem, a_lo_pc, a_hi_mem, a_hi_pc} = '0;
    {b_sel_ac, b_sel_ones, b_sel_one} = '0;
    {op_add, op_and, op_incxor, ac_wr, ac_clr, link_wr} = '0;
  endtask

  // load accumulator through the normal path: A = ma, B = none, add
  task automatic load_ac(input logic [W-1:0] v);
    @(negedge clk);
    idle();
    ma_i = v; a_sel_ma = 1'b1; op_add = 1'b1; ac_wr = 1'b1;
    @(negedge clk);
    idle();
  endtask

  initial begin
    rst_n = 1'b0;
    ma_i = '0; pc_i = '0; mem_i = '0;
    idle();
    model_link = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 ac reset", {1'b0, ac_q}, 13'd0);
    chk("R11 link reset", {12'd0, link_q}, 13'd0);
    chk("R10 zero at reset", {12'd0, ac_zero}, 13'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: field selection sweep
    for (int i = 0; i < 64; i++) begin
      for (int s = 0; s < 64; s++) begin
        logic [W-1:0] ea;
        @(negedge clk);
        idle();
        ma_i = sample_val(i); mem_i = sample_val((i + 17) % 64); pc_i = sample_val((i + 41) % 64);
        {a_sel_ma, a_sel_ones, a_lo_mem, a_lo_pc, a_hi_mem, a_hi_pc} = s[5:0];
        op_add = 1'b1;
        ea = (a_sel_ma ? ma_i : '0) | (a_sel_ones ? 12'o7777 : '0)
           | (((a_lo_mem ? mem_i : '0) | (a_lo_pc ? pc_i : '0)) & LOMASK)
           | (((a_hi_mem ? mem_i : '0) | (a_hi_pc ? pc_i : '0)) & ~LOMASK);
        #1;
        chk("R1 operand A", {carry_out, result}, {1'b0, ea});
      end
    end

    // R2: B select sweep with stored AC
    for (int i = 0; i < 16; i++) begin
      load_ac(sample_val(i * 3));
      chk("R8 ac load", {1'b0, ac_q}, {1'b0, sample_val(i * 3)});
      chk("R10 zero flag", {12'd0, ac_zero}, {12'd0, sample_val(i * 3) == 12'd0});
      for (int s = 0; s < 8; s++) begin
        logic [W-1:0] eb;
        @(negedge clk);
        idle();
        {b_sel_ac, b_sel_ones, b_sel_one} = s[2:0];
        op_add = 1'b1;
        eb = (b_sel_ac ? sample_val(i * 3) : '0) | (b_sel_ones ? 12'o7777 : '0)
           | (b_sel_one ? 12'o0001 : '0);
        #1;
        chk("R2 operand B", {carry_out, result}, {1'b0, eb});
      end
    end

    // R3 R4 R5 R6 R7: operation sweep A = ma, B = AC
    for (int bi = 0; bi < 64; bi++) begin
      logic [W-1:0] bv;
      bv = sample_val(bi);
      load_ac(bv);
      for (int ai = 0; ai < 64; ai++) begin
        logic [W-1:0] av;
        logic [W:0] e;
        av = sample_val(ai);
        for (int o = 0; o < 4; o++) begin
          @(negedge clk);
          idle();
          ma_i = av; a_sel_ma = 1'b1; b_sel_ac = 1'b1;
          op_add = (o == 1); op_and = (o == 2); op_incxor = (o == 3);
          case (o)
            1: e = 13'(int'(av) + int'(bv));
            2: e = {1'b0, av & bv};
            3: e = 13'(int'(av ^ bv) + 1);
            default: e = '0;
          endcase
          #1;
          case (o)
            1: chk("R3 add", {carry_out, result}, e);
            2: chk("R4 and", {carry_out, result}, e);
            3: chk("R5 incxor", {carry_out, result}, e);
            default: chk("R6 no op", {carry_out, result}, e);
          endcase
          chk("R7 new link", {12'd0, new_link}, {12'd0, model_link ^ e[W]});
        end
      end
      // R9: write link using add of ma + AC
      @(negedge clk);
      idle();
      ma_i = sample_val(63 - bi); a_sel_ma = 1'b1; b_sel_ac = 1'b1; op_add = 1'b1;
      link_wr = 1'b1;
      model_link = model_link ^ ((int'(sample_val(63 - bi)) + int'(bv)) > 4095);
      @(negedge clk);
      idle();
      chk("R9 link write", {12'd0, link_q}, {12'd0, model_link});
      @(negedge clk);
      ma_i = 12'o7777; a_sel_ma = 1'b1; b_sel_ones = 1'b1; op_add = 1'b1;
      @(negedge clk);
      idle();
      chk("R9 link hold", {12'd0, link_q}, {12'd0, model_link});
      chk("R8 ac hold", {1'b0, ac_q}, {1'b0, bv});
    end

    // R8: clear wins over write
    load_ac(12'o5252);
    @(negedge clk);
    idle();
    ma_i = 12'o1234; a_sel_ma = 1'b1; op_add = 1'b1; ac_wr = 1'b1; ac_clr = 1'b1;
    @(negedge clk);
    idle();
    chk("R8 clear priority", {1'b0, ac_q}, 13'd0);
    chk("R10 zero after clear", {12'd0, ac_zero}, 13'd1);

    // R5 boundary: A^B all ones gives carry
    load_ac(12'o0707);
    @(negedge clk);
    idle();
    ma_i = 12'o7070; a_sel_ma = 1'b1; b_sel_ac = 1'b1; op_incxor = 1'b1;
    #1;
    chk("R5 incxor wrap", {carry_out, result}, {1'b1, 12'o0000});

    // R3: page addressing cases through add with B = 0001
    @(negedge clk);
    idle();
    mem_i = 12'o5321; pc_i = 12'o6543;
    a_lo_mem = 1'b1; a_hi_pc = 1'b1; b_sel_one = 1'b1; op_add = 1'b1;
    #1;
    chk("R3 current page plus one", {carry_out, result}, {1'b0, 12'o6522});
    @(negedge clk);
    idle();
    a_lo_mem = 1'b1; b_sel_one = 1'b1; op_add = 1'b1;
    #1;
    chk("R3 page zero plus one", {carry_out, result}, {1'b0, 12'o0122});

    @(negedge clk);
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule